// File: doc/BRIEF.md
# Erasure-Only Outer Codeword Repair

This block sits behind a per-chunk inner decoder. It takes in one long outer codeword made of 32-byte chunks, eight carrying data and two carrying parity. Each chunk arrives with its position inside the codeword and with a flag. The flag is raised when the inner decoder gave up on that chunk. The block does not look for errors itself. It trusts the flags as erasure positions and rebuilds only the flagged chunks from the other chunks in the codeword. All 32 byte lanes are solved side by side. Each lane is an independent Reed-Solomon codeword of ten symbols over GF(2^8).

Chunks may arrive in any order. Once every position has been seen, the block stops accepting input. It then streams the ten chunks out in position order, one per handshake. A codeword with no flags goes out straight from the buffer with a bypass mark. A codeword with one or two flags takes one extra solve cycle. A codeword with more flags than the parity can cover is dropped and reported with a status pulse.

Both streams use valid/ready. A beat moves on a rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged. Input is back-pressured for the whole time a codeword is being solved, emitted or rejected.

Top module: `erasure_repair`

## Requirements
- R1: `in_ready` is high only while the block is gathering a codeword. It is low from the cycle after the edge that completes a codeword until the edge that accepts the last output beat, or through the uncorrectable pulse.
- R2: A codeword is complete once each position 0 to 9 has been accepted at least once, in any order. A repeated position replaces both the stored data and the stored flag of that position.
- R3: Output beats carry positions 0 to 9 in ascending order, one per accepted beat. While `out_ready` is low, the beat on `out_valid`, `out_data`, `out_idx` and `out_fixed` is held.
- R4: An unflagged chunk is emitted bit-for-bit as received, with `out_fixed` low.
- R5: The code defines the lanes. For every lane l, the byte c_k of chunk k satisfies XOR_k c_k = 0 and XOR_k c_k·α^k = 0 (k = 0..9, α = 0x02, field polynomial 0x11D). Parity chunks are positions 8 and 9. With one flagged chunk, that chunk is emitted with the value these equations give and `out_fixed` high, whatever data arrived with it.
- R6: With two flagged chunks, at any two positions (data or parity), both are emitted with their rebuilt values and `out_fixed` high.
- R7: With three or more flagged chunks, `cw_uncorr` is high for exactly one cycle, the cycle after the completing edge. No output beat is produced for that codeword, and `in_ready` returns high on the next cycle.
- R8: With no flagged chunk, `out_valid` rises in the cycle after the completing edge. `out_bypass` is then high on all ten beats.
- R9: With one or two flagged chunks, `out_valid` rises two cycles after the completing edge, and `out_bypass` stays low.
- R10: After reset, `in_ready` is high, and `out_valid`, `out_bypass` and `cw_uncorr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input chunk present |
| in_ready | output | 1 | Block accepts an input chunk |
| in_data | input | 256 | Chunk contents, byte lane l in bits 8l+7..8l |
| in_idx | input | 4 | Position of the chunk in the codeword, 0..9 |
| in_erased | input | 1 | Inner decoder could not correct this chunk |
| out_valid | output | 1 | Output chunk present |
| out_ready | input | 1 | Downstream accepts the output chunk |
| out_data | output | 256 | Repaired or passed-through chunk |
| out_idx | output | 4 | Position of the output chunk |
| out_fixed | output | 1 | This chunk was rebuilt |
| out_bypass | output | 1 | Codeword had no flags; emitted straight from the buffer |
| cw_uncorr | output | 1 | One-cycle pulse: codeword had more flags than parity can repair |

## Verification
Every result is due a fixed number of cycles after the edge that completes a codeword. The bypass beat and the uncorrectable pulse are due one cycle after that edge. The first rebuilt-codeword beat is due two cycles after it. Each later beat is due one cycle after the previous one is accepted. The bench's reference model records the edge that completes a codeword and sets these due cycles from it. Each cycle, just after the edge, the model compares `in_ready`, `out_valid` and `cw_uncorr` against what it expects for that cycle. Whenever a beat is present, it also compares the data and tags of that beat with the head of its queue. The expected contents come from bench-side field arithmetic done by shift-and-add, not from lookup tables.

// File: rtl/ers_pkg.sv
package ers_pkg;

  localparam int        PAR_CHUNKS = 2;
  localparam logic [8:0] GF_POLY   = 9'h11D;

  typedef logic [7:0] gf_tab_t [256];

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_SOLVE,
    ST_EMIT,
    ST_FAIL
  } ers_state_e;

  // powers of alpha, entry 255 wraps back to 1
  function automatic gf_tab_t gf_build_exp();
    gf_tab_t    t;
    logic [8:0] x;
    x = 9'd1;
    for (int i = 0; i < 256; i++) begin
      t[i] = x[7:0];
      x    = {x[7:0], 1'b0};
      if (x[8]) x = x ^ GF_POLY;
    end
    return t;
  endfunction

  function automatic gf_tab_t gf_build_log();
    gf_tab_t e;
    gf_tab_t t;
    e = gf_build_exp();
    for (int i = 0; i < 256; i++) t[i] = 8'h00;
    for (int i = 0; i < 255; i++) t[e[i]] = 8'(i);
    return t;
  endfunction

  localparam gf_tab_t GF_EXP = gf_build_exp();
  localparam gf_tab_t GF_LOG = gf_build_log();

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    if (a == 8'h00 || b == 8'h00) return 8'h00;
    s = {1'b0, GF_LOG[a]} + {1'b0, GF_LOG[b]};
    if (s >= 9'd255) s = s - 9'd255;
    return GF_EXP[s[7:0]];
  endfunction

  // caller guarantees b != 0
  function automatic logic [7:0] gf_div(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    if (a == 8'h00) return 8'h00;
    s = {1'b0, GF_LOG[a]} + 9'd255 - {1'b0, GF_LOG[b]};
    if (s >= 9'd255) s = s - 9'd255;
    return GF_EXP[s[7:0]];
  endfunction

endpackage

// File: rtl/ers_chunk_buf.sv
module ers_chunk_buf #(
  parameter int CHUNK_W = 256,
  parameter int N_CHUNK = 10,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CHUNK_W-1:0] wr_data,
  input  logic               wr_erased,
  input  logic               clr,
  output logic [CHUNK_W-1:0] rd_chunk [N_CHUNK],
  output logic [N_CHUNK-1:0] seen_q,
  output logic [N_CHUNK-1:0] flags_q,
  output logic [N_CHUNK-1:0] seen_nx,
  output logic [N_CHUNK-1:0] flags_nx
);

  logic [N_CHUNK-1:0] sel;

  always_comb begin
    sel = '0;
    if (wr_en && (int'(wr_idx) < N_CHUNK)) sel[wr_idx] = 1'b1;
  end

  // a repeated position overwrites its flag as well as its data
  assign seen_nx  = seen_q | sel;
  assign flags_nx = (flags_q & ~sel) | (wr_erased ? sel : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      flags_q <= '0;
    end else if (clr) begin
      seen_q  <= '0;
      flags_q <= '0;
    end else begin
      seen_q  <= seen_nx;
      flags_q <= flags_nx;
    end
  end

  for (genvar k = 0; k < N_CHUNK; k++) begin : g_slot
    logic [CHUNK_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (sel[k]) slot_q <= wr_data;
    end
    assign rd_chunk[k] = slot_q;
  end

endmodule

// File: rtl/ers_erase_pick.sv
module ers_erase_pick #(
  parameter int N_CHUNK = 10,
  parameter int IDX_W   = 4
) (
  input  logic [N_CHUNK-1:0] flags,
  output logic [IDX_W-1:0]   pos_a,
  output logic [IDX_W-1:0]   pos_b,
  output logic               dual
);

  int found;

  always_comb begin
    pos_a = '0;
    pos_b = '0;
    found = 0;
    for (int k = 0; k < N_CHUNK; k++) begin
      if (flags[k]) begin
        if (found == 0)      pos_a = IDX_W'(k);
        else if (found == 1) pos_b = IDX_W'(k);
        found = found + 1;
      end
    end
    dual = (found == 2);
  end

endmodule

// File: rtl/ers_lane_solver.sv
module ers_lane_solver
  import ers_pkg::*;
#(
  parameter int N_CHUNK = 10,
  parameter int IDX_W   = 4
) (
  input  logic [7:0]         col [N_CHUNK],
  input  logic [N_CHUNK-1:0] flags,
  input  logic [IDX_W-1:0]   pos_a,
  input  logic [IDX_W-1:0]   pos_b,
  input  logic               dual,
  output logic [7:0]         fix_a,
  output logic [7:0]         fix_b
);

  logic [7:0] s0, s1, wa, wb, num, den;

  // partial checks over surviving symbols, then a 2x2 solve
  always_comb begin
    s0 = 8'h00;
    s1 = 8'h00;
    for (int k = 0; k < N_CHUNK; k++) begin
      if (!flags[k]) begin
        s0 = s0 ^ col[k];
        s1 = s1 ^ gf_mul(col[k], GF_EXP[k]);
      end
    end
    wa    = GF_EXP[8'(pos_a)];
    wb    = GF_EXP[8'(pos_b)];
    num   = s1 ^ gf_mul(s0, wa);
    den   = wa ^ wb;
    fix_b = dual ? gf_div(num, den) : 8'h00;
    fix_a = s0 ^ fix_b;
  end

endmodule

// File: rtl/erasure_repair.sv
module erasure_repair
  import ers_pkg::*;
#(
  parameter  int CHUNK_BYTES = 32,
  parameter  int DATA_CHUNKS = 8,
  localparam int N_CHUNK     = DATA_CHUNKS + PAR_CHUNKS,
  localparam int IDX_W       = $clog2(N_CHUNK),
  localparam int CHUNK_W     = CHUNK_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHUNK_W-1:0] in_data,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic               in_erased,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CHUNK_W-1:0] out_data,
  output logic [IDX_W-1:0]   out_idx,
  output logic               out_fixed,
  output logic               out_bypass,
  output logic               cw_uncorr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHUNK - 1);

  ers_state_e         state_q;
  logic [IDX_W-1:0]   emit_idx_q;
  logic               clean_q;
  logic [CHUNK_W-1:0] fix_a_q, fix_b_q;
  logic [CHUNK_W-1:0] fix_a_nx, fix_b_nx;

  logic [CHUNK_W-1:0] rd_chunk [N_CHUNK];
  logic [N_CHUNK-1:0] seen_q, flags_q, seen_nx, flags_nx;
  logic [IDX_W-1:0]   pos_a, pos_b;
  logic               dual;

  logic in_fire, out_fire, complete, last_beat, clr;
  int   nx_cnt;

  assign in_ready  = (state_q == ST_COLLECT);
  assign out_valid = (state_q == ST_EMIT);
  assign cw_uncorr = (state_q == ST_FAIL);

  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign complete  = in_fire && (&seen_nx);
  assign nx_cnt    = $countones(flags_nx);
  assign last_beat = out_fire && (emit_idx_q == LAST_IDX);
  assign clr       = last_beat || (state_q == ST_FAIL);

  ers_chunk_buf #(
    .CHUNK_W (CHUNK_W),
    .N_CHUNK (N_CHUNK),
    .IDX_W   (IDX_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_fire),
    .wr_idx    (in_idx),
    .wr_data   (in_data),
    .wr_erased (in_erased),
    .clr       (clr),
    .rd_chunk  (rd_chunk),
    .seen_q    (seen_q),
    .flags_q   (flags_q),
    .seen_nx   (seen_nx),
    .flags_nx  (flags_nx)
  );

  ers_erase_pick #(
    .N_CHUNK (N_CHUNK),
    .IDX_W   (IDX_W)
  ) u_pick (
    .flags (flags_q),
    .pos_a (pos_a),
    .pos_b (pos_b),
    .dual  (dual)
  );

  for (genvar l = 0; l < CHUNK_BYTES; l++) begin : g_lane
    logic [7:0] col [N_CHUNK];
    logic [7:0] pass_byte;

    for (genvar k = 0; k < N_CHUNK; k++) begin : g_col
      assign col[k] = rd_chunk[k][8*l +: 8];
    end

    ers_lane_solver #(
      .N_CHUNK (N_CHUNK),
      .IDX_W   (IDX_W)
    ) u_solve (
      .col   (col),
      .flags (flags_q),
      .pos_a (pos_a),
      .pos_b (pos_b),
      .dual  (dual),
      .fix_a (fix_a_nx[8*l +: 8]),
      .fix_b (fix_b_nx[8*l +: 8])
    );

    assign pass_byte = rd_chunk[emit_idx_q][8*l +: 8];
    assign out_data[8*l +: 8] =
      !flags_q[emit_idx_q]    ? pass_byte :
      (emit_idx_q == pos_a)   ? fix_a_q[8*l +: 8] : fix_b_q[8*l +: 8];
  end

  assign out_idx    = emit_idx_q;
  assign out_fixed  = out_valid && flags_q[emit_idx_q];
  assign out_bypass = out_valid && clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_COLLECT;
      emit_idx_q <= '0;
      clean_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (complete) begin
            emit_idx_q <= '0;
            if (nx_cnt == 0) begin
              state_q <= ST_EMIT;
              clean_q <= 1'b1;
            end else if (nx_cnt <= PAR_CHUNKS) begin
              state_q <= ST_SOLVE;
              clean_q <= 1'b0;
            end else begin
              state_q <= ST_FAIL;
              clean_q <= 1'b0;
            end
          end
        end
        ST_SOLVE: state_q <= ST_EMIT;
        ST_EMIT: begin
          if (out_fire) begin
            emit_idx_q <= emit_idx_q + 1'b1;
            if (emit_idx_q == LAST_IDX) begin
              state_q    <= ST_COLLECT;
              emit_idx_q <= '0;
            end
          end
        end
        ST_FAIL: state_q <= ST_COLLECT;
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  // rebuilt symbols are captured once, in the solve cycle
  always_ff @(posedge clk) begin
    if (state_q == ST_SOLVE) begin
      fix_a_q <= fix_a_nx;
      fix_b_q <= fix_b_nx;
    end
  end

endmodule

// File: rtl/ers_checker.sv
module ers_checker #(
  parameter int CHUNK_W = 256,
  parameter int IDX_W   = 4,
  parameter int N_CHUNK = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CHUNK_W-1:0] out_data,
  input logic [IDX_W-1:0]   out_idx,
  input logic               out_fixed,
  input logic               out_bypass,
  input logic               cw_uncorr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHUNK - 1);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx) && $stable(out_fixed)); // R3

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_idx != LAST_IDX) |=> out_valid && (out_idx == IDX_W'($past(out_idx) + 1'b1))); // R3

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0)); // R3

  AST_NO_IN_DURING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1

  AST_UNCORR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cw_uncorr |=> !cw_uncorr && in_ready); // R7

  AST_UNCORR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cw_uncorr |-> !out_valid && !in_ready); // R7

  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_bypass |-> out_valid && !out_fixed); // R8

  AST_BYPASS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> (out_bypass == $past(out_bypass))); // R8

endmodule

bind erasure_repair ers_checker #(
  .CHUNK_W (CHUNK_W),
  .IDX_W   (IDX_W),
  .N_CHUNK (N_CHUNK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_idx    (out_idx),
  .out_fixed  (out_fixed),
  .out_bypass (out_bypass),
  .cw_uncorr  (cw_uncorr)
);

// File: tb/sim_erasure_repair.sv
module sim_erasure_repair;

  localparam int CB = 32;
  localparam int NC = 10;
  localparam int CW = CB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_data = '0;
  logic [3:0]    in_idx = '0;
  logic          in_erased = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [CW-1:0] out_data;
  logic [3:0]    out_idx;
  logic          out_fixed;
  logic          out_bypass;
  logic          cw_uncorr;

  erasure_repair u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_idx(in_idx), .in_erased(in_erased),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_idx(out_idx), .out_fixed(out_fixed), .out_bypass(out_bypass),
    .cw_uncorr(cw_uncorr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  logic [CW-1:0] q_data[$];
  int            q_idx[$];
  bit            q_fixed[$];
  bit            q_byp[$];
  string         q_tag[$];
  int            due_valid = 0;
  bit            pend_uncorr = 0;
  int            uncorr_due = 0;
  bit            bp = 0;
  logic [15:0]   lfsr = 16'hACE1;

  logic [CW-1:0] ref_cw [NC];
  int            ord [NC];

  initial forever begin
    @(posedge clk);
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // bench-side field arithmetic, shift-and-add
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bpow(input int k);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < k; i++) r = bmul(r, 8'h02);
    return r;
  endfunction

  // fill data chunks and compute the two parity chunks (R5 code definition)
  task automatic make_cw(input bit zero);
    logic [7:0] den, inv, s0, s1, d, p9;
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < CB / 4; w++)
        ref_cw[k][32*w +: 32] = zero ? 32'h0 : $urandom;
    end
    den = bpow(8) ^ bpow(9);
    inv = 8'h00;
    for (int b = 1; b < 256; b++) if (bmul(den, 8'(b)) == 8'h01) inv = 8'(b);
    for (int l = 0; l < CB; l++) begin
      s0 = 8'h00;
      s1 = 8'h00;
      for (int k = 0; k < 8; k++) begin
        d  = ref_cw[k][8*l +: 8];
        s0 = s0 ^ d;
        s1 = s1 ^ bmul(d, bpow(k));
      end
      p9 = bmul(s1 ^ bmul(s0, bpow(8)), inv);
      ref_cw[9][8*l +: 8] = p9;
      ref_cw[8][8*l +: 8] = s0 ^ p9;
    end
  endtask

  task automatic set_order(input int mode);
    int j, t;
    for (int k = 0; k < NC; k++) ord[k] = (mode == 1) ? (NC - 1 - k) : k;
    if (mode == 2) begin
      for (int k = NC - 1; k > 0; k--) begin
        j = $urandom % (k + 1);
        t = ord[k]; ord[k] = ord[j]; ord[j] = t;
      end
    end
  endtask

  task automatic push_beat(input int idx, input logic [CW-1:0] d, input bit er, output int acc);
    @(negedge clk);
    in_valid  = 1'b1;
    in_idx    = 4'(idx);
    in_data   = d;
    in_erased = er;
    while (!in_ready) @(negedge clk);
    acc = cyc + 1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic garbage(output logic [CW-1:0] g);
    for (int w = 0; w < CB / 4; w++) g[32*w +: 32] = $urandom | 32'h1;
  endtask

  task automatic send_cw(input logic [NC-1:0] flags, input bit dup);
    int acc, n;
    logic [CW-1:0] g, d;
    n = $countones(flags);
    if (dup) begin
      garbage(g);
      push_beat(4, g, 1'b1, acc);
    end
    for (int p = 0; p < NC; p++) begin
      int k;
      k = ord[p];
      garbage(g);
      d = flags[k] ? (ref_cw[k] ^ g) : ref_cw[k];
      push_beat(k, d, flags[k], acc);
    end
    if (n > 2) begin
      pend_uncorr = 1'b1;
      uncorr_due  = acc;
    end else begin
      due_valid = (n == 0) ? acc : acc + 1;
      for (int k = 0; k < NC; k++) begin
        q_data.push_back(ref_cw[k]);
        q_idx.push_back(k);
        q_fixed.push_back(flags[k]);
        q_byp.push_back(n == 0);
        if (dup && k == 4)  q_tag.push_back("R2");
        else if (!flags[k]) q_tag.push_back("R4");
        else if (n == 1)    q_tag.push_back("R5");
        else                q_tag.push_back("R6");
      end
    end
  endtask

  task automatic wait_idle();
    while (q_data.size() != 0 || pend_uncorr) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // per-cycle comparison, sampled 2 ns after each rising edge
  initial forever begin
    bit ev, eu, er;
    @(posedge clk);
    #2;
    if (!rst_n) continue;
    out_ready = bp ? lfsr[0] : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ev = (q_data.size() != 0) && (cyc >= due_valid);
    eu = pend_uncorr && (cyc == uncorr_due);
    er = !((q_data.size() != 0) || pend_uncorr);
    chk(in_ready == er, "R1", "in_ready", CW'(in_ready), CW'(er));
    chk(out_valid == ev, "R9", "out_valid", CW'(out_valid), CW'(ev));
    chk(cw_uncorr == eu, "R7", "cw_uncorr", CW'(cw_uncorr), CW'(eu));
    if (ev && out_valid) begin
      chk(out_data == q_data[0], q_tag[0], "out_data", out_data, q_data[0]);
      chk(int'(out_idx) == q_idx[0], "R3", "out_idx", CW'(out_idx), CW'(q_idx[0]));
      chk(out_fixed == q_fixed[0], q_tag[0], "out_fixed", CW'(out_fixed), CW'(q_fixed[0]));
      chk(out_bypass == q_byp[0], "R8", "out_bypass", CW'(out_bypass), CW'(q_byp[0]));
      if (out_ready) begin
        void'(q_data.pop_front());
        void'(q_idx.pop_front());
        void'(q_fixed.pop_front());
        void'(q_byp.pop_front());
        void'(q_tag.pop_front());
      end
    end
    if (pend_uncorr && cyc >= uncorr_due) pend_uncorr = 1'b0;
  end

  initial begin
    wait (cyc >= 100000);
    errors = errors + 1;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10", "in_ready after reset", CW'(in_ready), CW'(1));
    chk(out_valid == 1'b0 && out_bypass == 1'b0, "R10", "out_valid/out_bypass after reset",
        CW'({out_valid, out_bypass}), CW'(0));
    chk(cw_uncorr == 1'b0, "R10", "cw_uncorr after reset", CW'(cw_uncorr), CW'(0));

    // R8 R4: clean codeword in order
    make_cw(0); set_order(0); send_cw(10'b0, 0); wait_idle();
    // R5: one data chunk flagged
    make_cw(0); set_order(0); send_cw(10'b0000001000, 0); wait_idle();
    // R5: parity chunk flagged, reverse arrival
    make_cw(0); set_order(1); send_cw(10'b1000000000, 0); wait_idle();
    // R6: first and last flagged, shuffled arrival
    make_cw(0); set_order(2); send_cw(10'b1000000001, 0); wait_idle();
    // R6: both parity chunks flagged
    make_cw(0); set_order(0); send_cw(10'b1100000000, 0); wait_idle();
    // R6 R3: two data flags under output back-pressure
    bp = 1;
    make_cw(0); set_order(2); send_cw(10'b0000100100, 0); wait_idle();
    bp = 0;
    // R7: three flags, then a clean codeword straight after
    make_cw(0); set_order(0); send_cw(10'b0010010010, 0);
    make_cw(0); set_order(1); send_cw(10'b0, 0); wait_idle();
    // R2: position 4 sent twice, second copy unflagged
    make_cw(0); set_order(2); send_cw(10'b0000000001, 1); wait_idle();
    // R6: all-zero codeword, two flags
    make_cw(1); set_order(0); send_cw(10'b0000000011, 0); wait_idle();

    for (int r = 0; r < 14; r++) begin
      logic [NC-1:0] f;
      int nf;
      f  = '0;
      nf = $urandom % 4;
      for (int i = 0; i < nf; i++) begin
        int p;
        p = $urandom % NC;
        while (f[p]) p = (p + 1) % NC;
        f[p] = 1'b1;
      end
      bp = r[0];
      make_cw(0); set_order(2); send_cw(f, 0); wait_idle();
    end
    bp = 0;
    summary();
  end

endmodule